// File: doc/BRIEF.md
# Multiplexed Bus Read Initiator

This block is the requesting side of a synchronous read burst on a shared parallel bus. A single set of 32 pins carries the address first and the data words after it. A local agent hands the block a start address, a 4-bit command code and a word count. The block drives the address phase, releases the shared pins for one turnaround cycle, and then collects data words. A word moves only on a clock edge where the block and the target both signal ready.

The burst length is known only to this block. It marks the final data phase by dropping its transaction-active strobe while its own ready strobe is still asserted. On the cycle after that transfer every control line goes inactive. A local consumer sees each word on a valid/data output with a last-word flag. The consumer's readiness drives the initiator ready strobe directly, so back-pressure from the consumer turns into wait states on the bus. If no target claims the cycle within a fixed window, the block gives up and pulses an error flag.

Top module: `mbus_read_master`

## Requirements
- R1: `cmd_ready` is high only while no burst is in progress, including the cycle after reset. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high.
- R2: In the cycle after a command is taken (the address phase), `bus_start_n` is low and `bus_ad_oe` is high. In that cycle `bus_ad_o` equals the command address, `bus_cmd_o` equals the command code and `init_rdy_n` is high.
- R3: The cycle after the address phase is a turnaround. In it `bus_ad_oe` is low, `bus_start_n` stays low and `init_rdy_n` is high. `bus_ad_oe` stays low for the rest of the burst.
- R4: A word moves only in a cycle where `init_rdy_n`, `tgt_rdy_n` and `tgt_claim_n` are all low. In exactly those cycles `rsp_valid` is high and `rsp_data` equals `bus_ad_i`.
- R5: During data phases, `init_rdy_n` is the inverse of `rsp_ready`. A low `rsp_ready` therefore inserts initiator wait states, and the burst continues afterwards without restarting.
- R6: In every data phase except the final one, `bus_start_n` is low. In the final data phase it is high whenever `init_rdy_n` is low.
- R7: `rsp_last` is high with the final word only. In the cycle after that word, `bus_start_n` and `init_rdy_n` are high, `bus_ad_oe` is low and `cmd_ready` is high.
- R8: A word count of 0 is taken as a count of 1.
- R9: Counting the turnaround cycle as cycle 0, if `tgt_claim_n` has not been low by cycle `CLAIM_WAIT-1`, `rsp_err` is high for that one cycle. No word is delivered, and the bus is idle on the next cycle.
- R10: A claimed burst of N words delivers exactly N words, in the order the target presents them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Local command offered |
| cmd_ready | output | 1 | Block idle and taking a command |
| cmd_addr | input | 32 | Start address of the burst |
| cmd_code | input | 4 | Command code sent with the address |
| cmd_count | input | 8 | Number of words to read (0 means 1) |
| rsp_ready | input | 1 | Consumer can take a word this cycle |
| rsp_valid | output | 1 | A word is delivered this cycle |
| rsp_data | output | 32 | Delivered word |
| rsp_last | output | 1 | Delivered word is the final one |
| rsp_err | output | 1 | One-cycle pulse: no target claimed the cycle |
| bus_ad_o | output | 32 | Shared address/data pins, outgoing value |
| bus_ad_oe | output | 1 | Drive enable for the shared pins |
| bus_ad_i | input | 32 | Shared address/data pins, incoming value |
| bus_cmd_o | output | 4 | Command lines, valid while `bus_ad_oe` is high |
| bus_start_n | output | 1 | Transaction-active strobe, active low |
| init_rdy_n | output | 1 | Initiator ready strobe, active low |
| tgt_claim_n | input | 1 | Target claims the cycle, active low |
| tgt_rdy_n | input | 1 | Target ready strobe, active low |

## Verification
The assertions assume a consumer that keeps `rsp_ready` high, once raised in a data phase, until a word arrives. Without that, the strobe rule in R6 could be undone by the consumer. They also assume a target that raises `tgt_rdy_n` low only while it also holds `tgt_claim_n` low. The stimulus meets both assumptions. The bench consumer raises its ready at random and then holds it until the transfer. The bench target picks a claim delay shorter than the timeout window, or never claims at all, and randomises its ready only after it has claimed. Commands are issued only while `cmd_ready` is high, so every burst starts on an idle bus.

// File: rtl/mrb_pkg.sv
// Package: shared state encoding for the multiplexed-bus read initiator.
// Assumes: one burst at a time; four phases cover the whole read.
package mrb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_TURN = 2'd2,
        ST_DATA = 2'd3
    } mrb_state_e;
endpackage

// File: rtl/mrb_beat_counter.sv
// Module: counts the words still owed in the burst and flags the final one.
// Assumes: load and dec are never high together; a zero count loads as one.
module mrb_beat_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last
);
    logic [CNT_W-1:0] remain;

    // Purpose: hold the remaining word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= (load_val == '0) ? CNT_W'(1) : load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - CNT_W'(1);
        end
    end

    // Purpose: one word left means the current data phase is the final one.
    always_comb last = (remain == CNT_W'(1));
endmodule

// File: rtl/mrb_claim_timer.sv
// Module: watches for the target claim after the address phase and
// reports expiry when no claim arrived within CLAIM_WAIT cycles.
// Assumes: clear is high in the address phase; watch covers turnaround and data.
module mrb_claim_timer #(
    parameter int CLAIM_WAIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic watch,
    input  logic claim_now,
    output logic claimed,
    output logic expired
);
    localparam int TW = $clog2(CLAIM_WAIT + 1);
    logic [TW-1:0] waited;

    // Purpose: count unclaimed cycles and remember a claim once seen.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            waited  <= '0;
            claimed <= 1'b0;
        end else if (watch) begin
            if (claim_now) claimed <= 1'b1;
            if (!claimed && waited != TW'(CLAIM_WAIT)) waited <= waited + TW'(1);
        end
    end

    // Purpose: last allowed cycle passed without any claim.
    always_comb expired = watch && !claimed && !claim_now
                          && (waited == TW'(CLAIM_WAIT - 1));
endmodule

// File: rtl/mrb_seq.sv
// Module: phase sequencer, idle -> address -> turnaround -> data -> idle.
// Assumes: xfer only occurs in the data phase; expired only while watching.
module mrb_seq
    import mrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       xfer,
    input  logic       last,
    input  logic       expired,
    output mrb_state_e state
);
    mrb_state_e nxt;

    // Purpose: choose the next phase.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (cmd_valid) nxt = ST_ADDR;
            ST_ADDR: nxt = ST_TURN;
            ST_TURN: nxt = expired ? ST_IDLE : ST_DATA;
            ST_DATA: if (expired || (xfer && last)) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // Purpose: phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/mbus_read_master.sv
// Module: read-burst initiator for a bus with shared address/data pins.
// Drives the address phase, a turnaround, then data phases with the
// ready handshake; ends the burst by releasing the start strobe on the
// final phase. Consumer readiness drives the initiator ready strobe.
// Assumes: the bus is idle whenever cmd_ready is high (arbitration is
// outside); the consumer holds rsp_ready until a word arrives once raised.
module mbus_read_master
    import mrb_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int CMD_W      = 4,
    parameter int CNT_W      = 8,
    parameter int CLAIM_WAIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [DATA_W-1:0] cmd_addr,
    input  logic [CMD_W-1:0]  cmd_code,
    input  logic [CNT_W-1:0]  cmd_count,
    input  logic              rsp_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_last,
    output logic              rsp_err,
    output logic [DATA_W-1:0] bus_ad_o,
    output logic              bus_ad_oe,
    input  logic [DATA_W-1:0] bus_ad_i,
    output logic [CMD_W-1:0]  bus_cmd_o,
    output logic              bus_start_n,
    output logic              init_rdy_n,
    input  logic              tgt_claim_n,
    input  logic              tgt_rdy_n
);
    mrb_state_e        state;
    logic              take_cmd;
    logic              in_addr, in_turn, in_data;
    logic              claim_now, claimed, expired;
    logic              last, xfer;
    logic [DATA_W-1:0] addr_q;
    logic [CMD_W-1:0]  code_q;

    // Purpose: decode the current phase.
    always_comb begin
        in_addr  = (state == ST_ADDR);
        in_turn  = (state == ST_TURN);
        in_data  = (state == ST_DATA);
        cmd_ready = (state == ST_IDLE);
        take_cmd = cmd_ready && cmd_valid;
        claim_now = !tgt_claim_n;
        xfer     = in_data && rsp_ready && !tgt_rdy_n && claim_now;
    end

    // Purpose: capture address and command when a burst is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            code_q <= '0;
        end else if (take_cmd) begin
            addr_q <= cmd_addr;
            code_q <= cmd_code;
        end
    end

    mrb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .xfer      (xfer),
        .last      (last),
        .expired   (expired),
        .state     (state)
    );

    mrb_beat_counter #(.CNT_W(CNT_W)) u_beats (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (take_cmd),
        .load_val (cmd_count),
        .dec      (xfer),
        .last     (last)
    );

    mrb_claim_timer #(.CLAIM_WAIT(CLAIM_WAIT)) u_claim (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (in_addr),
        .watch     (in_turn || in_data),
        .claim_now (claim_now),
        .claimed   (claimed),
        .expired   (expired)
    );

    // Purpose: drive the bus-side pins from the phase.
    always_comb begin
        bus_ad_oe   = in_addr;
        bus_ad_o    = in_addr ? addr_q : '0;
        bus_cmd_o   = in_addr ? code_q : '0;
        init_rdy_n  = !(in_data && rsp_ready);
        bus_start_n = !(in_addr || in_turn || (in_data && !(last && rsp_ready)));
    end

    // Purpose: present delivered words and the no-claim pulse locally.
    always_comb begin
        rsp_valid = xfer;
        rsp_data  = bus_ad_i;
        rsp_last  = xfer && last;
        rsp_err   = expired;
    end
endmodule

// File: rtl/mbus_read_master_chk.sv
// Module: protocol checker for mbus_read_master, attached by bind.
// Assumes: consumer and target obey the input rules stated in the brief.
module mbus_read_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_ready,
    input logic rsp_ready,
    input logic rsp_valid,
    input logic rsp_last,
    input logic rsp_err,
    input logic bus_ad_oe,
    input logic bus_start_n,
    input logic init_rdy_n,
    input logic tgt_claim_n,
    input logic tgt_rdy_n
);
    a_r1_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (bus_start_n && init_rdy_n && !bus_ad_oe));

    a_r2_addr_phase_drives: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_start_n) |-> (bus_ad_oe && init_rdy_n));

    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ad_oe |=> (!bus_ad_oe && !bus_start_n && init_rdy_n));

    a_r4_word_needs_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!init_rdy_n && !tgt_rdy_n && !tgt_claim_n));

    a_r5_irdy_from_consumer: assert property (@(posedge clk) disable iff (!rst_n)
        !init_rdy_n |-> rsp_ready);

    a_r6_final_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start_n && !init_rdy_n && !tgt_rdy_n && !tgt_claim_n) |-> rsp_last);

    a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_last) |=> (bus_start_n && init_rdy_n && !bus_ad_oe && cmd_ready));

    a_r9_err_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |=> (bus_start_n && init_rdy_n && cmd_ready));

    a_r9_err_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_valid);
endmodule

bind mbus_read_master mbus_read_master_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_ready   (cmd_ready),
    .rsp_ready   (rsp_ready),
    .rsp_valid   (rsp_valid),
    .rsp_last    (rsp_last),
    .rsp_err     (rsp_err),
    .bus_ad_oe   (bus_ad_oe),
    .bus_start_n (bus_start_n),
    .init_rdy_n  (init_rdy_n),
    .tgt_claim_n (tgt_claim_n),
    .tgt_rdy_n   (tgt_rdy_n)
);

// File: tb/sim_mbus_read_master.sv
module sim_mbus_read_master;
    localparam int CW = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [31:0] cmd_addr = '0;
    logic [3:0]  cmd_code = '0;
    logic [7:0]  cmd_count = '0;
    logic        rsp_ready = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_last;
    logic        rsp_err;
    logic [31:0] bus_ad_o;
    logic        bus_ad_oe;
    logic [31:0] bus_ad_i = '0;
    logic [3:0]  bus_cmd_o;
    logic        bus_start_n;
    logic        init_rdy_n;
    logic        tgt_claim_n = 1'b1;
    logic        tgt_rdy_n = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #4 clk = ~clk;   // 125 MHz

    mbus_read_master #(.CLAIM_WAIT(CW)) u0 (.*);

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [31:0] a, input int idx);
        return (a + 32'(idx) * 32'd4) ^ 32'h5A5A_0000;
    endfunction

    function automatic bit pct(input int p);
        return ($urandom_range(99) < p);
    endfunction

    // dly: claim delay in cycles counted from turnaround (0); negative = never
    task automatic run_txn(input logic [31:0] a, input logic [3:0] c, input logic [7:0] n,
                           input int dly, input int rdy_pct, input int trdy_pct);
        int  words = (n == 0) ? 1 : int'(n);
        int  idx = 0;
        int  k = 1;
        bit  holding = 1'b0;
        bit  done = 1'b0;
        bit  cl;
        bit  xf;
        @(negedge clk);
        cmd_addr = a; cmd_code = c; cmd_count = n; cmd_valid = 1'b1;
        #1;
        chk(cmd_ready == 1'b1, "R1 ready when idle", 32'(cmd_ready), 32'd1);
        @(negedge clk);
        cmd_valid = 1'b0; rsp_ready = 1'b0; tgt_claim_n = 1'b1; tgt_rdy_n = 1'b1;
        #1;
        chk(!bus_start_n && bus_ad_oe && init_rdy_n, "R2 address phase strobes",
            {29'd0, bus_start_n, bus_ad_oe, init_rdy_n}, 32'b011);
        chk(bus_ad_o == a, "R2 address on pins", bus_ad_o, a);
        chk(bus_cmd_o == c, "R2 command code", 32'(bus_cmd_o), 32'(c));
        chk(cmd_ready == 1'b0, "R1 busy in burst", 32'(cmd_ready), 32'd0);
        @(negedge clk);
        tgt_claim_n = (dly == 0) ? 1'b0 : 1'b1;
        #1;
        chk(!bus_ad_oe && !bus_start_n && init_rdy_n, "R3 turnaround",
            {29'd0, bus_start_n, bus_ad_oe, init_rdy_n}, 32'b001);
        while (!done) begin
            @(negedge clk);
            cl = (dly >= 0) && (k >= dly);
            tgt_claim_n = !cl;
            tgt_rdy_n = !(cl && pct(trdy_pct));
            if (!holding) rsp_ready = pct(rdy_pct);
            bus_ad_i = !tgt_rdy_n ? exp_word(a, idx) : 32'hDEAD_BEEF;
            #1;
            chk(init_rdy_n == !rsp_ready, "R5 initiator ready follows consumer",
                32'(init_rdy_n), 32'(!rsp_ready));
            chk(!bus_ad_oe, "R3 pins released in data", 32'(bus_ad_oe), 32'd0);
            xf = rsp_ready && !tgt_rdy_n && cl;
            if (xf) begin
                chk(rsp_valid, "R4 word valid on handshake", 32'(rsp_valid), 32'd1);
                chk(rsp_data == exp_word(a, idx), "R10 word order", rsp_data, exp_word(a, idx));
                chk(rsp_last == (idx == words - 1), "R7 last flag", 32'(rsp_last), 32'(idx == words - 1));
                chk(bus_start_n == (idx == words - 1), "R6 start strobe on final phase",
                    32'(bus_start_n), 32'(idx == words - 1));
                idx++;
                if (idx == words) done = 1'b1;
            end else begin
                chk(!rsp_valid, "R4 no word without handshake", 32'(rsp_valid), 32'd0);
                if (dly < 0 && k == CW - 1) begin
                    chk(rsp_err, "R9 no-claim error", 32'(rsp_err), 32'd1);
                    done = 1'b1;
                end else begin
                    chk(!rsp_err, "R9 no spurious error", 32'(rsp_err), 32'd0);
                    if (idx < words - 1 || !rsp_ready)
                        chk(!bus_start_n, "R6 strobe held before final", 32'(bus_start_n), 32'd0);
                end
            end
            holding = rsp_ready && !xf;
            k++;
            if (k > 5000) begin
                chk(1'b0, "R10 burst stalled", 32'(idx), 32'(words));
                done = 1'b1;
            end
        end
        @(negedge clk);
        rsp_ready = 1'b0; tgt_claim_n = 1'b1; tgt_rdy_n = 1'b1;
        #1;
        chk(bus_start_n && init_rdy_n && !bus_ad_oe && cmd_ready, "R7 idle after burst",
            {28'd0, bus_start_n, init_rdy_n, bus_ad_oe, cmd_ready}, 32'b1101);
        chk(idx == ((dly < 0) ? 0 : words), "R10 word count (R8 zero count, R9 none on error)",
            32'(idx), 32'((dly < 0) ? 0 : words));
    endtask

    initial begin
        void'($urandom(32'h0000_2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(bus_start_n && init_rdy_n && !bus_ad_oe && cmd_ready && !rsp_valid && !rsp_err,
            "R1 reset state", {26'd0, bus_start_n, init_rdy_n, bus_ad_oe, cmd_ready, rsp_valid, rsp_err},
            32'b110100);
        run_txn(32'h1000_0000, 4'h6, 8'd1, 0, 100, 100);   // single word, no waits
        run_txn(32'h2000_0040, 4'hE, 8'd0, 1, 100, 100);   // R8 zero count
        run_txn(32'h3000_0000, 4'h6, 8'd3, -1, 100, 100);  // R9 never claimed
        run_txn(32'h4000_0100, 4'hC, 8'd4, 2, 20, 100);    // R5 heavy consumer waits
        run_txn(32'h5000_0200, 4'h6, 8'd5, 0, 100, 30);    // target waits
        for (int t = 0; t < 40; t++) begin
            int d = (($urandom_range(9)) == 0) ? -1 : int'($urandom_range(CW - 2));
            run_txn($urandom & 32'hFFFF_FFFC, 4'($urandom_range(15)), 8'($urandom_range(12)),
                    d, 30 + int'($urandom_range(70)), 30 + int'($urandom_range(70)));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule